// File: doc/BRIEF.md
# UART Status and Interrupt Unit

This block sits beside the transmit and receive shifters of a UART and turns their events into an 8-bit status word and one interrupt request line. The shifters report events as one-cycle pulses. These include the write into the transmit holding buffer, the move of that buffer into the shift register, and the 11th sample tick of the last stop bit on each direction. The receive side also supplies its error qualifiers with its pulse. Two active-low modem inputs, clear-to-send and data-set-ready, are resynchronised here and watched for changes.

Status bits always follow the events, whatever the enable settings. The interrupt line is driven from a latched request. A global enable gates transmit-complete and receive-error events. Modem changes need the global enable and a separate modem enable as well. Any read strobe drops the request. A status read also clears the latched error flags and the modem-change bit. A receive-buffer read clears data-ready.

Status layout: bit 7 data ready, bit 6 transmit holding empty, bit 5 transmission complete, bit 4 modem change, bit 3 break, bit 2 parity error, bit 1 framing error, bit 0 overrun.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset the status word is 8'h60 (holding empty and transmission complete set, all else clear) and `irq` is low.
- R2: `wr_thb` clears bit 6 on the next edge and `tx_hold_taken` sets it. When both arrive in the same cycle, the set wins.
- R3: `tx_stop_t11` with bit 6 set sets bit 5 on the next edge. With bit 6 clear, it does not. `wr_thb` clears bit 5, and a completion event in the same cycle wins.
- R4: `rx_stop_t11` sets bit 7 on the next edge and `rd_rxb` clears it. A new receive in the same cycle wins.
- R5: On `rx_stop_t11`, `rx_err[2]` (break) sets bit 3, `rx_err[1]` (parity) sets bit 2 and `rx_err[0]` (framing) sets bit 1. Bit 0 (overrun) is set when bit 7 is already set and `rd_rxb` is not asserted in that cycle.
- R6: `rd_stat` clears bits 4..0 on the next edge. An event in the same cycle keeps its bit set. Bits 7..5 are not touched by `rd_stat`.
- R7: A level change on `cts_n` or `dsr_n` passes a two-flop synchronizer and sets bit 4 on the third rising edge after the change.
- R8: With `gie` high, a completion event (R3) or a receive tick carrying any error from R5 raises `irq` on the next edge. With `gie` low, `irq` stays low while every status bit still updates.
- R9: A modem change raises `irq` only when both `gie` and `mie` are high.
- R10: `rd_stat` or `rd_rxb` drops `irq` on the next edge, unless an enabled event arrives in the same cycle, in which case `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| gie | input | 1 | Global interrupt enable |
| mie | input | 1 | Modem interrupt enable |
| wr_thb | input | 1 | Write strobe to the transmit holding buffer |
| tx_hold_taken | input | 1 | Holding buffer moved into the transmit shifter |
| tx_stop_t11 | input | 1 | 11th tick of the last transmit stop bit |
| rx_stop_t11 | input | 1 | 11th tick of the last receive stop bit |
| rx_err | input | 3 | Receive qualifiers {break, parity, framing}, valid with rx_stop_t11 |
| rd_stat | input | 1 | Status read strobe |
| rd_rxb | input | 1 | Receive buffer read strobe |
| status | output | 8 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle. It confirms that a read with no coinciding event always drops the request, and that the request never rises while the global enable is low. It also checks that a modem change alone never raises it without the modem enable. It covers the buffer-write clearing of the holding-empty bit, the completion, data-ready and overrun set rules, and the status-read clearing of the error bits. Other behaviours need the bench's scenarios. These include the three-edge latency through the synchronizer, the priority of a set over a clear in the same cycle, and the interplay between successive receives and reads. The exact status values after reset and along an event sequence also depend on those scenarios.

// File: rtl/uart_stat_irq.sv
module uart_stat_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       gie,
  input  logic       mie,
  input  logic       wr_thb,
  input  logic       tx_hold_taken,
  input  logic       tx_stop_t11,
  input  logic       rx_stop_t11,
  input  logic [2:0] rx_err,
  input  logic       rd_stat,
  input  logic       rd_rxb,
  output logic [7:0] status,
  output logic       irq
);

  logic [2:0] cts_s, dsr_s;
  logic dr, the, tc, ms, brk, pe, fe, oe;
  logic ms_chg, oe_evt, tc_evt, err_evt, irq_set;

  assign ms_chg  = (cts_s[2] ^ cts_s[1]) | (dsr_s[2] ^ dsr_s[1]);
  assign oe_evt  = rx_stop_t11 & dr & ~rd_rxb;
  assign tc_evt  = tx_stop_t11 & the;
  assign err_evt = rx_stop_t11 & ((|rx_err) | oe_evt);
  assign irq_set = gie & (tc_evt | err_evt | (mie & ms_chg));
  assign status  = {dr, the, tc, ms, brk, pe, fe, oe};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_s <= 3'b111;
      dsr_s <= 3'b111;
    end else begin
      cts_s <= {cts_s[1:0], cts_n};
      dsr_s <= {dsr_s[1:0], dsr_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr  <= 1'b0;
      the <= 1'b1;
      tc  <= 1'b1;
      ms  <= 1'b0;
      brk <= 1'b0;
      pe  <= 1'b0;
      fe  <= 1'b0;
      oe  <= 1'b0;
      irq <= 1'b0;
    end else begin
      dr  <= rx_stop_t11 | (dr & ~rd_rxb);
      the <= tx_hold_taken | (the & ~wr_thb);
      tc  <= tc_evt | (tc & ~wr_thb);
      ms  <= ms_chg | (ms & ~rd_stat);
      brk <= (rx_stop_t11 & rx_err[2]) | (brk & ~rd_stat);
      pe  <= (rx_stop_t11 & rx_err[1]) | (pe & ~rd_stat);
      fe  <= (rx_stop_t11 & rx_err[0]) | (fe & ~rd_stat);
      oe  <= oe_evt | (oe & ~rd_stat);
      irq <= irq_set | (irq & ~(rd_stat | rd_rxb));
    end
  end

endmodule

module uart_stat_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic       mie,
  input logic       wr_thb,
  input logic       tx_hold_taken,
  input logic       tx_stop_t11,
  input logic       rx_stop_t11,
  input logic [2:0] rx_err,
  input logic       rd_stat,
  input logic       rd_rxb,
  input logic       ms_chg,
  input logic [7:0] status,
  input logic       irq
);

  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat || rd_rxb) && !tx_stop_t11 && !rx_stop_t11 && !ms_chg |=> !irq); // R10

  AST_NO_IRQ_WITHOUT_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie && !irq |=> !irq); // R8

  AST_MODEM_NEEDS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
    !mie && !irq && !tx_stop_t11 && !rx_stop_t11 |=> !irq); // R9

  AST_WRITE_CLEARS_THE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thb && !tx_hold_taken |=> !status[6]); // R2

  AST_TC_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop_t11 && status[6] |=> status[5]); // R3

  AST_DR_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop_t11 |=> status[7]); // R4

  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop_t11 && status[7] && !rd_rxb |=> status[0]); // R5

  AST_READ_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !rx_stop_t11 |=> status[3:0] == 4'b0000); // R6

endmodule

bind uart_stat_irq uart_stat_irq_chk u_chk (.*);

// File: tb/sim_uart_stat_irq.sv
module sim_uart_stat_irq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1, gie = 1'b0, mie = 1'b0;
  logic wr_thb = 1'b0, tx_hold_taken = 1'b0, tx_stop_t11 = 1'b0, rx_stop_t11 = 1'b0;
  logic [2:0] rx_err = 3'b000;
  logic rd_stat = 1'b0, rd_rxb = 1'b0;
  logic [7:0] status;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_stat_irq u0 (.*);

  // {gie,mie,wr,taken,txt11,rxt11,err[2:0],rd_stat,rd_rxb, exp_status[7:0], exp_irq}
  localparam logic [19:0] VEC [16] = '{
    20'b1_0_1_0_0_0_000_0_0_00000000_0, // R2 R3 write clears 6 and 5
    20'b1_0_0_1_0_0_000_0_0_01000000_0, // R2 transfer sets 6
    20'b1_0_0_0_1_0_000_0_0_01100000_1, // R3 R8 completion
    20'b1_0_0_0_0_0_000_1_0_01100000_0, // R10 R6 read drops irq, keeps 5
    20'b1_0_0_0_0_1_001_0_0_11100010_1, // R4 R5 framing
    20'b1_0_0_0_0_0_000_0_1_01100010_0, // R4 R10 rx read
    20'b1_0_0_0_0_0_000_1_0_01100000_0, // R6 clear errors
    20'b0_0_0_0_0_1_000_0_0_11100000_0, // R8 status without gie
    20'b0_0_0_0_0_1_010_0_0_11100101_0, // R5 R8 parity + overrun, no irq
    20'b1_0_0_0_0_1_100_1_0_11101001_1, // R5 R6 R10 set wins over read
    20'b1_0_0_0_0_0_000_1_1_01100000_0, // R4 R6 both reads
    20'b1_0_1_1_0_0_000_0_0_01000000_0, // R2 transfer wins
    20'b1_0_1_0_1_0_000_0_0_00100000_1, // R3 completion wins over write
    20'b1_0_0_0_0_0_000_1_0_00100000_0, // R10
    20'b1_0_1_0_0_0_000_0_0_00000000_0, // R2 R3
    20'b1_0_0_0_1_0_000_0_0_00000000_0  // R3 holding full: no completion
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_clear();
    wr_thb = 0; tx_hold_taken = 0; tx_stop_t11 = 0; rx_stop_t11 = 0;
    rx_err = 3'b000; rd_stat = 0; rd_rxb = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", {status, irq}, {8'h60, 1'b0});

    for (int i = 0; i < 16; i++) begin
      {gie, mie, wr_thb, tx_hold_taken, tx_stop_t11, rx_stop_t11, rx_err, rd_stat, rd_rxb} = VEC[i][19:9];
      @(negedge clk);
      pulse_clear();
      chk($sformatf("R2-10 vector %0d", i), {status, irq}, VEC[i][8:0]);
    end

    // R7 R9: modem change, gie on, mie off
    gie = 1; mie = 0; cts_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R7 not yet after 2 edges", {8'h0, status[4]}, 9'h0);
    @(negedge clk);
    chk("R7 R9 change seen, no irq", {7'h0, status[4], irq}, {7'h0, 1'b1, 1'b0});
    rd_stat = 1; @(negedge clk); pulse_clear();
    chk("R6 read clears modem bit", {8'h0, status[4]}, 9'h0);

    // R9: both enables
    mie = 1; dsr_n = 0;
    repeat (3) @(negedge clk);
    chk("R9 modem irq", {7'h0, status[4], irq}, {7'h0, 1'b1, 1'b1});
    rd_stat = 1; @(negedge clk); pulse_clear();
    chk("R10 R6 read after modem", {7'h0, status[4], irq}, 9'h0);

    // R8 R9: gie off with mie on
    gie = 0; cts_n = 1;
    repeat (3) @(negedge clk);
    chk("R9 no irq without gie", {7'h0, status[4], irq}, {7'h0, 1'b1, 1'b0});

    // R1 mid-run reset
    gie = 1; rx_stop_t11 = 1; @(negedge clk); pulse_clear();
    rst_n = 0; @(negedge clk);
    chk("R1 reset mid-run", {status, irq}, {8'h60, 1'b0});
    rst_n = 1; @(negedge clk);
    chk("R1 after release", {status, irq}, {8'h60, 1'b0});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule